// File: doc/BRIEF.md
# Audio Link Codec Reset and Readiness Controller

This block sits on the codec side of a serial audio link and decides when the codec is in reset, when it is still settling, and when the mixer is ready. It tells a cold reset, which comes from the active-low reset pin, apart from a warm reset, which is a lone high pulse on the frame-sync line. Each kind of reset clears its own part of an 8-bit powerdown control register.

When the reset pin is released, the controller samples the sync and serial-data-out lines in the first clock cycle. Only if both are low does it start a fixed analog settling period of 516 frame ticks. After that period it raises the ready flag that the frame serializer places into the status slot.

While the reset pin is held low, all analog outputs are placed in high impedance and the beep path bypasses the mixer to the line outputs. The link clock enable follows the link-powerdown bit of the register.

Top module: `acl_rst_seq`

## Requirements
- R1: If `sync_i` or `sdo_i` is high in the first clock cycle after `rst_pin_n` rises, the controller does not start the settling period. Until the next low level on `rst_pin_n`, `ready_o` stays 0, `bclk_en_o` is 0 and register writes are ignored.
- R2: While `rst_pin_n` is low, `pd_reg_o` reads 8'h00 and `ready_o` is 0.
- R3: `beep_byp_o` is 1 exactly while `rst_pin_n` is low. Every bit of `ana_hiz_o` is 1 while `ready_o` is 0 and 0 while `ready_o` is 1.
- R4: Outside the state of R1, `bclk_en_o` is the inverse of bit 4 (link powerdown) of `pd_reg_o`. This includes the time while `rst_pin_n` is low.
- R5: After a valid release, `ready_o` stays 0 through 515 pulses of `fs_tick_i` and reads 1 in the clock cycle after the 516th pulse.
- R6: A low level on `rst_pin_n` during the settling period restarts the tick count from zero, so a full 516 more ticks are needed after the next valid release.
- R7: While ready, a high pulse on `sync_i` that lasts L clock cycles, with L >= 1 and L != 16, clears bits 5 and 4 of `pd_reg_o` in the cycle after `sync_i` falls. Bits 7:6 and 3:0 are kept.
- R8: A `sync_i` high time of exactly 16 cycles is a frame start and leaves `pd_reg_o` unchanged.
- R9: A warm-reset pulse is honored only when `bclk_en_o` is 1 or `ext_clk_i` is 1. Otherwise it is ignored.
- R10: `wr_en_i` loads `wr_data_i` into `pd_reg_o` on the next clock edge only while `ready_o` is 1. Writes during reset or settling are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock domain clock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous assert |
| sync_i | input | 1 | Frame-sync line |
| sdo_i | input | 1 | Serial data line from the controller |
| fs_tick_i | input | 1 | One-cycle pulse per audio frame |
| ext_clk_i | input | 1 | An external link clock is present |
| wr_en_i | input | 1 | Powerdown register write strobe |
| wr_data_i | input | 8 | Powerdown register write value |
| ready_o | output | 1 | Codec ready, for the status slot |
| bclk_en_o | output | 1 | Link bit clock generator enable |
| ana_hiz_o | output | 4 | High-impedance control per analog output |
| beep_byp_o | output | 1 | Route beep straight to the line outputs |
| pd_reg_o | output | 8 | Powerdown control register contents |

## Verification
The assertions assume that `rst_pin_n` changes away from the clock edge and that `sync_i`, `sdo_i`, `wr_en_i` and `fs_tick_i` are synchronous to `clk`. They also assume that reset is low at the first edge, so that the register and the ready flag start from known values. The bench drives every input on the falling clock edge and asserts the reset pin from time zero. Warm-reset write and pulse tests are kept in separate cycles, so that each assertion on register scope sees only one cause of change.

// File: rtl/acl_rst_pkg.sv
package acl_rst_pkg;

  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_INIT  = 2'd1,
    ST_READY = 2'd2,
    ST_BLOCK = 2'd3
  } seq_st_e;

  // A sync high time qualifies as warm reset when long enough and not a frame
  function automatic logic warm_len_ok(input int unsigned len,
                                       input int unsigned min_hi,
                                       input int unsigned frame_hi);
    return (len >= min_hi) && (len != frame_hi);
  endfunction

  function automatic logic [7:0] warm_scrub(input logic [7:0] pd,
                                            input logic [7:0] mask);
    return pd & ~mask;
  endfunction

endpackage

// File: rtl/acl_sync_cls.sv
module acl_sync_cls #(
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned MIN_HI   = 1,
  parameter int unsigned FRAME_HI = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic warm_o
);
  import acl_rst_pkg::*;

  logic             sync_q;
  logic [CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      hi_cnt <= '0;
    end else begin
      sync_q <= sync_i;
      if (!sync_i)
        hi_cnt <= '0;
      else if (hi_cnt != {CNT_W{1'b1}})
        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // falling edge of sync, with the measured high time
  assign warm_o = !sync_i && sync_q && warm_len_ok(32'(hi_cnt), MIN_HI, FRAME_HI);

endmodule

// File: rtl/acl_init_timer.sv
module acl_init_timer #(
  parameter int unsigned FRAMES = 516,
  localparam int unsigned CNT_W = $clog2(FRAMES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run_i)
      cnt <= '0;
    else if (tick_i)
      cnt <= cnt + 1'b1;
  end

  assign done_o = run_i && tick_i && (cnt == CNT_W'(FRAMES - 1));

endmodule

// File: rtl/acl_pd_reg.sv
module acl_pd_reg #(
  parameter int unsigned  PD_W     = 8,
  parameter logic [7:0]   CLR_MASK = 8'h30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ok_i,
  input  logic            wr_en_i,
  input  logic [PD_W-1:0] wr_data_i,
  input  logic            warm_i,
  output logic [PD_W-1:0] pd_o
);
  import acl_rst_pkg::*;

  logic [PD_W-1:0] pd_q, pd_d;

  always_comb begin
    pd_d = pd_q;
    if (wr_ok_i && wr_en_i) pd_d = wr_data_i;
    if (warm_i)             pd_d = PD_W'(warm_scrub(8'(pd_d), CLR_MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= '0;
    else        pd_q <= pd_d;
  end

  assign pd_o = pd_q;

endmodule

// File: rtl/acl_rst_seq.sv
module acl_rst_seq #(
  parameter int unsigned INIT_FRAMES = 516,
  parameter int unsigned PD_W        = 8,
  parameter int unsigned LINK_BIT    = 4,
  parameter logic [7:0]  WARM_MASK   = 8'h30,
  parameter int unsigned WARM_MIN_HI = 1,
  parameter int unsigned FRAME_HI    = 16,
  parameter int unsigned SYNC_CNT_W  = 6,
  parameter int unsigned N_ANA       = 4
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             sync_i,
  input  logic             sdo_i,
  input  logic             fs_tick_i,
  input  logic             ext_clk_i,
  input  logic             wr_en_i,
  input  logic [PD_W-1:0]  wr_data_i,
  output logic             ready_o,
  output logic             bclk_en_o,
  output logic [N_ANA-1:0] ana_hiz_o,
  output logic             beep_byp_o,
  output logic [PD_W-1:0]  pd_reg_o
);
  import acl_rst_pkg::*;

  seq_st_e st;
  logic    init_done;
  logic    warm_evt;
  logic    warm_take;
  logic    st_block;

  // cold-reset state machine, pin low forces the arm state
  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      st <= ST_ARM;
    end else begin
      case (st)
        ST_ARM:  st <= (!sync_i && !sdo_i) ? ST_INIT : ST_BLOCK;
        ST_INIT: if (init_done) st <= ST_READY;
        default: st <= st;
      endcase
    end
  end

  acl_init_timer #(.FRAMES(INIT_FRAMES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_pin_n),
    .run_i  (st == ST_INIT),
    .tick_i (fs_tick_i),
    .done_o (init_done)
  );

  acl_sync_cls #(
    .CNT_W    (SYNC_CNT_W),
    .MIN_HI   (WARM_MIN_HI),
    .FRAME_HI (FRAME_HI)
  ) u_cls (
    .clk    (clk),
    .rst_n  (rst_pin_n),
    .sync_i (sync_i),
    .warm_o (warm_evt)
  );

  assign st_block  = (st == ST_BLOCK);
  assign bclk_en_o = !st_block && !pd_reg_o[LINK_BIT];
  assign warm_take = warm_evt && (st == ST_READY) && (bclk_en_o || ext_clk_i);

  acl_pd_reg #(.PD_W(PD_W), .CLR_MASK(WARM_MASK)) u_pd (
    .clk       (clk),
    .rst_n     (rst_pin_n),
    .wr_ok_i   (st == ST_READY),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .warm_i    (warm_take),
    .pd_o      (pd_reg_o)
  );

  assign ready_o    = (st == ST_READY);
  assign beep_byp_o = !rst_pin_n;

  for (genvar g = 0; g < N_ANA; g++) begin : g_hiz
    assign ana_hiz_o[g] = !ready_o;
  end

endmodule

// File: rtl/acl_rst_seq_chk.sv
module acl_rst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       bclk_en,
  input logic       wr_en,
  input logic [7:0] pd,
  input logic       blocked,
  input logic       init_done,
  input logic       warm_take
);

  a_r5_ready_from_timer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(init_done));

  a_r1_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (!ready && !bclk_en));

  a_r7_warm_scope: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_take && !wr_en) |=> (pd[5:4] == 2'b00 && pd[3:0] == $past(pd[3:0])
                               && pd[7:6] == $past(pd[7:6])));

  a_r10_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready) |=> $stable(pd));

  always @(posedge clk) begin
    if (rst_n === 1'b0)
      a_r2_reset_defaults: assert (pd == 8'h00 && !ready);
  end

endmodule

bind acl_rst_seq acl_rst_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_pin_n),
  .ready     (ready_o),
  .bclk_en   (bclk_en_o),
  .wr_en     (wr_en_i),
  .pd        (pd_reg_o),
  .blocked   (st_block),
  .init_done (init_done),
  .warm_take (warm_take)
);

// File: tb/acl_rst_seq_bench.sv
module acl_rst_seq_bench;

  logic       clk = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic       sync_i = 1'b0, sdo_i = 1'b0, fs_tick_i = 1'b0;
  logic       ext_clk_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       ready_o, bclk_en_o, beep_byp_o;
  logic [3:0] ana_hiz_o;
  logic [7:0] pd_reg_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  acl_rst_seq u_acl_rst_seq (
    .clk(clk), .rst_pin_n(rst_pin_n), .sync_i(sync_i), .sdo_i(sdo_i),
    .fs_tick_i(fs_tick_i), .ext_clk_i(ext_clk_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .ready_o(ready_o), .bclk_en_o(bclk_en_o),
    .ana_hiz_o(ana_hiz_o), .beep_byp_o(beep_byp_o), .pd_reg_o(pd_reg_o)
  );

  // sync pulse lengths and whether each must act as warm reset
  localparam int PLEN [6] = '{1, 3, 15, 16, 17, 40};
  localparam bit PWARM[6] = '{1, 1, 1, 0, 1, 1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fs_tick_i = 1'b1;
      @(negedge clk) fs_tick_i = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic pulse(input int len);
    @(negedge clk) sync_i = 1'b1;
    repeat (len) @(negedge clk);
    sync_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic cold(input bit good);
    @(negedge clk); rst_pin_n = 1'b0; sdo_i = 1'b0; sync_i = !good;
    repeat (3) @(negedge clk);
    chk("R2 pd in reset", pd_reg_o, 8'h00);
    chk("R2 ready in reset", ready_o, 0);
    chk("R3 beep in reset", beep_byp_o, 1);
    chk("R3 hiz in reset", ana_hiz_o, 4'hF);
    chk("R4 bclk in reset", bclk_en_o, 1);
    rst_pin_n = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    @(negedge clk);
    chk("R3 beep after release", beep_byp_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // valid cold reset, settling timed by ticks
    cold(1);
    ticks(515);
    chk("R5 not ready at 515", ready_o, 0);
    chk("R3 hiz during settle", ana_hiz_o, 4'hF);
    wr(8'hFF);
    chk("R10 write during settle ignored", pd_reg_o, 8'h00);
    ticks(1);
    chk("R5 ready at 516", ready_o, 1);
    chk("R3 hiz off when ready", ana_hiz_o, 4'h0);

    // link clock enable follows bit 4
    wr(8'h10);
    chk("R4 bclk off with bit4", bclk_en_o, 0);
    wr(8'h00);
    chk("R4 bclk on without bit4", bclk_en_o, 1);

    // pulse-length table with external clock present
    ext_clk_i = 1'b1;
    for (int v = 0; v < 6; v++) begin
      wr(8'hFF);
      pulse(PLEN[v]);
      chk(PWARM[v] ? "R7 warm clears bits 5:4" : "R8 frame-length sync ignored",
          pd_reg_o, PWARM[v] ? 8'hCF : 8'hFF);
    end

    // warm reset needs a running clock
    ext_clk_i = 1'b0;
    wr(8'hFF);
    pulse(3);
    chk("R9 warm ignored without clock", pd_reg_o, 8'hFF);
    wr(8'h2F);
    pulse(3);
    chk("R9 warm with bit clock running", pd_reg_o, 8'h0F);

    wr(8'hA5);
    chk("R10 write when ready", pd_reg_o, 8'hA5);

    // reset during settling restarts the count
    cold(1);
    ticks(300);
    cold(1);
    ticks(515);
    chk("R6 count restarted", ready_o, 0);
    ticks(1);
    chk("R6 ready after full count", ready_o, 1);

    // release with sync high: no cold reset
    cold(0);
    ticks(600);
    chk("R1 bad edge keeps not ready", ready_o, 0);
    chk("R1 bad edge bclk off", bclk_en_o, 0);
    wr(8'hFF);
    chk("R1 write ignored when blocked", pd_reg_o, 8'h00);
    cold(1);
    ticks(516);
    chk("R1 recovery after valid edge", ready_o, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule